// File: doc/BRIEF.md
# UART Receive Data-Ready and Overrun Flag Controller

This block is the receive half of a UART register interface. A receive shift register outside the block reports each finished character as a one-cycle strobe that carries the character. The block moves that character into a holding data register and keeps two status flags. The data-ready flag shows that a character is waiting. The overrun flag shows that a character was lost because the previous one was never collected.

Software and a DMA engine share the data register. A CPU read of the data register and a DMA read acknowledge both empty it. Software that lets DMA drain the data can also drop the data-ready flag directly, by writing zero to that bit of the status register. An interrupt output follows the data-ready flag when the interrupt enable is set. A DMA request output follows the same flag when DMA reception is enabled.

The flag logic is built as a four-state machine that tracks the pair (data-ready, overrun). A second, two-state machine tracks the overrun clear sequence.

Top module: `uart_rx_status`

## Requirements
- R1: On a `char_valid` strobe when the holding register is free (the flag is 0, or it is being cleared in the same cycle), the character is latched into the data register and the data-ready flag reads 1 from the next cycle.
- R2: `irq` is 1 exactly when the interrupt enable (control bit 0) is 1 and the data-ready flag is 1.
- R3: A bus read of the data register (address 1) clears the data-ready flag on the following edge.
- R4: A bus write to the status register (address 0) with bit 0 equal to 0 clears the data-ready flag.
- R5: A status write with bit 0 equal to 1 leaves the data-ready flag unchanged. Writes to status bit 1 never change the overrun flag. Writes to the data register address have no effect.
- R6: A `char_valid` strobe while the data-ready flag is 1, with no clear in the same cycle, sets the overrun flag. The overrun flag is status bit 1.
- R7: On an overrun the data register keeps the earlier character and the new one is discarded.
- R8: The overrun flag clears only after a status read that sees it set, followed later by a data read (CPU or DMA). If a new overrun occurs in that same cycle, it wins.
- R9: `dma_req` is 1 exactly when the DMA enable (control bit 1) is 1 and the data-ready flag is 1. A `dma_ack` pulse clears the flag the same way a CPU data read does.
- R10: When a clear and a `char_valid` strobe arrive in the same cycle, the new character is latched, the data-ready flag stays 1, and no overrun is reported.
- R11: After reset the data-ready flag, the overrun flag, both enables, `irq` and `dma_req` are 0.
- R12: Register map: address 0 is status (bit 0 data-ready, bit 1 overrun), address 1 is data, and address 2 is control (bit 0 interrupt enable, bit 1 DMA enable, readable). Address 3 reads as 0. Read data is combinational from the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_valid | input | 1 | One-cycle strobe: a character has completed |
| char_data | input | DATA_W | The completed character |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for the addressed register |
| dma_ack | input | 1 | DMA engine has read the data register |
| irq | output | 1 | Receive interrupt |
| dma_req | output | 1 | DMA receive request |

## Verification
A wrong data-ready state shows on `irq` or `dma_req` one cycle after the event that caused it, provided the matching enable is set. It shows at once in a status read. A wrong overrun state, or a wrong state of the clear sequence, stays hidden until the next status read. The bench therefore mixes frequent status reads into random traffic, so that such an error surfaces within a few cycles. A wrong data register shows in the next data read, and directed cases compare it right after overruns and same-cycle races.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;

    localparam int unsigned ADDR_W_DEF = 2;

    localparam logic [1:0] ADDR_STAT = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam int unsigned BIT_RDY = 0;
    localparam int unsigned BIT_OVR = 1;
    localparam int unsigned BIT_IEN = 0;
    localparam int unsigned BIT_DEN = 1;

    // Pair of flags {overrun, ready} held as a named state.
    typedef enum logic [1:0] {
        FL_EMPTY      = 2'b00,
        FL_FULL       = 2'b01,
        FL_EMPTY_LOST = 2'b10,
        FL_FULL_LOST  = 2'b11
    } flag_state_t;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_t;

endpackage

// File: rtl/rxs_bus_decode.sv
module rxs_bus_decode
    import uart_rxs_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned BUS_W  = 8
) (
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              dma_ack,
    output logic              data_evt,
    output logic              stat_rd,
    output logic              rdy_clr,
    output logic              ctl_wr
);
    logic hit_stat;
    logic hit_data;
    logic hit_ctrl;
    logic unused_wbits;

    assign hit_stat = (bus_addr == ADDR_W'(ADDR_STAT));
    assign hit_data = (bus_addr == ADDR_W'(ADDR_DATA));
    assign hit_ctrl = (bus_addr == ADDR_W'(ADDR_CTRL));

    always_comb begin
        data_evt = (bus_rd_en && hit_data) || dma_ack;
        stat_rd  = bus_rd_en && hit_stat;
        rdy_clr  = data_evt || (bus_wr_en && hit_stat && !bus_wdata[BIT_RDY]);
        ctl_wr   = bus_wr_en && hit_ctrl;
    end

    assign unused_wbits = ^bus_wdata;
endmodule

// File: rtl/rxs_flag_fsm.sv
module rxs_flag_fsm
    import uart_rxs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic new_char,
    input  logic rdy_clr,
    input  logic ovr_clr,
    output logic ready,
    output logic overrun,
    output logic load_en
);
    flag_state_t state_q;
    flag_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_EMPTY: begin
                if (new_char) state_d = FL_FULL;
            end
            FL_FULL: begin
                if (new_char) state_d = rdy_clr ? FL_FULL : FL_FULL_LOST;
                else if (rdy_clr) state_d = FL_EMPTY;
            end
            FL_FULL_LOST: begin
                if (new_char)
                    state_d = (rdy_clr && ovr_clr) ? FL_FULL : FL_FULL_LOST;
                else if (rdy_clr)
                    state_d = ovr_clr ? FL_EMPTY : FL_EMPTY_LOST;
                else if (ovr_clr)
                    state_d = FL_FULL;
            end
            FL_EMPTY_LOST: begin
                if (new_char) state_d = ovr_clr ? FL_FULL : FL_FULL_LOST;
                else if (ovr_clr) state_d = FL_EMPTY;
            end
            default: state_d = FL_EMPTY;
        endcase
    end

    always_comb begin
        ready   = 1'b0;
        overrun = 1'b0;
        load_en = 1'b0;
        unique case (state_q)
            FL_EMPTY: begin
                load_en = new_char;
            end
            FL_FULL: begin
                ready   = 1'b1;
                load_en = new_char && rdy_clr;
            end
            FL_FULL_LOST: begin
                ready   = 1'b1;
                overrun = 1'b1;
                load_en = new_char && rdy_clr;
            end
            FL_EMPTY_LOST: begin
                overrun = 1'b1;
                load_en = new_char;
            end
            default: begin
                ready = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rxs_ovr_seq.sv
module rxs_ovr_seq
    import uart_rxs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic data_evt,
    input  logic overrun,
    output logic ovr_clr
);
    seq_state_t seq_q;
    seq_state_t seq_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_IDLE;
        else        seq_q <= seq_d;
    end

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q)
            SEQ_IDLE:  if (!data_evt && stat_rd && overrun) seq_d = SEQ_ARMED;
            SEQ_ARMED: if (data_evt) seq_d = SEQ_IDLE;
            default:   seq_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        ovr_clr = 1'b0;
        unique case (seq_q)
            SEQ_IDLE:  ovr_clr = 1'b0;
            SEQ_ARMED: ovr_clr = data_evt;
            default:   ovr_clr = 1'b0;
        endcase
    end
endmodule

// File: rtl/rxs_hold_regs.sv
module rxs_hold_regs
    import uart_rxs_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned BUS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] char_data,
    input  logic              ctl_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0] data_q,
    output logic              ien_q,
    output logic              den_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data_q <= '0;
        else if (load_en) data_q <= char_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= 1'b0;
            den_q <= 1'b0;
        end else if (ctl_wr) begin
            ien_q <= bus_wdata[BIT_IEN];
            den_q <= bus_wdata[BIT_DEN];
        end
    end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rxs_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned BUS_W  = 8,
    parameter int unsigned ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [DATA_W-1:0] char_data,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              dma_ack,
    output logic              irq,
    output logic              dma_req
);
    localparam int unsigned PAD_W = BUS_W - DATA_W;

    logic              data_evt;
    logic              stat_rd;
    logic              rdy_clr;
    logic              ctl_wr;
    logic              ovr_clr;
    logic              rdy_q;
    logic              ovr_q;
    logic              load_en;
    logic [DATA_W-1:0] data_q;
    logic              ien_q;
    logic              den_q;
    logic [BUS_W-1:0]  data_ext;

    rxs_bus_decode #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dec (
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .dma_ack   (dma_ack),
        .data_evt  (data_evt),
        .stat_rd   (stat_rd),
        .rdy_clr   (rdy_clr),
        .ctl_wr    (ctl_wr)
    );

    rxs_flag_fsm u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .new_char (char_valid),
        .rdy_clr  (rdy_clr),
        .ovr_clr  (ovr_clr),
        .ready    (rdy_q),
        .overrun  (ovr_q),
        .load_en  (load_en)
    );

    rxs_ovr_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_rd  (stat_rd),
        .data_evt (data_evt),
        .overrun  (ovr_q),
        .ovr_clr  (ovr_clr)
    );

    rxs_hold_regs #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .char_data (char_data),
        .ctl_wr    (ctl_wr),
        .bus_wdata (bus_wdata),
        .data_q    (data_q),
        .ien_q     (ien_q),
        .den_q     (den_q)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign data_ext = {{PAD_W{1'b0}}, data_q};
        end else begin : g_nopad
            assign data_ext = data_q;
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_STAT)) begin
            bus_rdata[BIT_RDY] = rdy_q;
            bus_rdata[BIT_OVR] = ovr_q;
        end else if (bus_addr == ADDR_W'(ADDR_DATA)) begin
            bus_rdata = data_ext;
        end else if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
            bus_rdata[BIT_IEN] = ien_q;
            bus_rdata[BIT_DEN] = den_q;
        end
    end

    assign irq     = ien_q && rdy_q;
    assign dma_req = den_q && rdy_q;
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk
    import uart_rxs_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned BUS_W  = 8,
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              char_valid,
    input logic [DATA_W-1:0] char_data,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              dma_ack,
    input logic              irq,
    input logic              dma_req,
    input logic              rdy_q,
    input logic              ovr_q,
    input logic [DATA_W-1:0] data_q
);
    logic cpu_drd;
    logic any_clr;
    logic ctl_w;
    logic st_w0;
    logic st_w1;

    assign cpu_drd = bus_rd_en && (bus_addr == ADDR_W'(ADDR_DATA));
    assign ctl_w   = bus_wr_en && (bus_addr == ADDR_W'(ADDR_CTRL));
    assign st_w0   = bus_wr_en && (bus_addr == ADDR_W'(ADDR_STAT)) && !bus_wdata[BIT_RDY];
    assign st_w1   = bus_wr_en && (bus_addr == ADDR_W'(ADDR_STAT)) && bus_wdata[BIT_RDY];
    assign any_clr = cpu_drd || dma_ack || st_w0;

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && (!rdy_q || any_clr)) |=> (rdy_q && data_q == $past(char_data)));

    p_irq_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !char_valid && !any_clr && !ctl_w) |=> irq);

    p_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_drd && !char_valid) |=> !rdy_q);

    p_write0_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_w0 && !char_valid) |=> !rdy_q);

    p_write1_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_w1 && rdy_q && !dma_ack) |=> rdy_q);

    p_overrun_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && rdy_q && !any_clr) |=> ovr_q);

    p_old_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && rdy_q && !any_clr) |=> $stable(data_q));

    p_overrun_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !cpu_drd && !dma_ack) |=> ovr_q);

    p_dma_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !char_valid) |=> (!rdy_q && !dma_req && !irq));

    p_race_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && any_clr && !ovr_q) |=> (rdy_q && !ovr_q));
endmodule

bind uart_rx_status uart_rx_status_chk #(
    .DATA_W(DATA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_valid (char_valid),
    .char_data  (char_data),
    .bus_wr_en  (bus_wr_en),
    .bus_rd_en  (bus_rd_en),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .dma_ack    (dma_ack),
    .irq        (irq),
    .dma_req    (dma_req),
    .rdy_q      (rdy_q),
    .ovr_q      (ovr_q),
    .data_q     (data_q)
);

// File: tb/uart_rx_status_test.sv
`timescale 1ns/1ps
module uart_rx_status_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_valid = 1'b0;
    logic [7:0] char_data = '0;
    logic       bus_wr_en = 1'b0;
    logic       bus_rd_en = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       dma_ack = 1'b0;
    logic       irq;
    logic       dma_req;

    int total = 0;
    int bad = 0;

    logic       m_rdy = 0, m_ovr = 0, m_arm = 0, m_ien = 0, m_den = 0;
    logic [7:0] m_dat = '0;

    always #2.5 clk = ~clk;

    uart_rx_status uut (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
        .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_ack(dma_ack),
        .irq(irq), .dma_req(dma_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {6'd0, m_ovr, m_rdy};
            2'd1:    return m_dat;
            2'd2:    return {6'd0, m_den, m_ien};
            default: return 8'd0;
        endcase
    endfunction

    // One bus cycle, driven just after a falling edge.
    task automatic cyc(input bit cv, input logic [7:0] cd, input bit wr, input bit rd,
                       input logic [1:0] a, input logic [7:0] wd, input bit ack,
                       input string tag);
        bit data_evt, st_rd, clr, oc, n_rdy, n_ovr, n_arm, load;
        char_valid = cv; char_data = cd; bus_wr_en = wr; bus_rd_en = rd;
        bus_addr = a; bus_wdata = wd; dma_ack = ack;
        #1;
        if (rd) check(bus_rdata == exp_read(a), tag, bus_rdata, exp_read(a));
        data_evt = (rd && a == 2'd1) || ack;
        st_rd    = rd && a == 2'd0;
        clr      = data_evt || (wr && a == 2'd0 && !wd[0]);
        oc       = m_arm && data_evt;
        n_rdy    = cv || (m_rdy && !clr);
        n_ovr    = (cv && m_rdy && !clr) || (m_ovr && !oc);
        load     = cv && (!m_rdy || clr);
        n_arm    = data_evt ? 1'b0 : ((st_rd && m_ovr) ? 1'b1 : m_arm);
        @(posedge clk);
        m_rdy = n_rdy; m_ovr = n_ovr; m_arm = n_arm;
        if (load) m_dat = cd;
        if (wr && a == 2'd2) begin m_ien = wd[0]; m_den = wd[1]; end
        @(negedge clk);
        char_valid = 0; bus_wr_en = 0; bus_rd_en = 0; dma_ack = 0;
        #0.5;
        check(irq == (m_ien && m_rdy), "R2 irq", irq, m_ien && m_rdy);
        check(dma_req == (m_den && m_rdy), "R9 dma_req", dma_req, m_den && m_rdy);
        @(negedge clk);
    endtask

    task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, "idle"); endtask
    task automatic rd_reg(input logic [1:0] a, input string tag); cyc(0, 0, 0, 1, a, 0, 0, tag); endtask
    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d); cyc(0, 0, 1, 0, a, d, 0, "wr"); endtask
    task automatic push(input logic [7:0] d); cyc(1, d, 0, 0, 0, 0, 0, "push"); endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        #0.5;
        check(irq == 0 && dma_req == 0, "R11 outputs at reset", {irq, dma_req}, 0);
        rst_n = 1;
        @(negedge clk);
        rd_reg(0, "R11 status after reset");
        rd_reg(2, "R11 control after reset");
        rd_reg(3, "R12 unmapped address");

        // R1 and R3: capture then CPU read clears
        wr_reg(2, 8'h01);
        push(8'h5A);
        rd_reg(0, "R1 ready set");
        rd_reg(1, "R1 data captured");
        rd_reg(0, "R3 cleared by data read");

        // R4 and R5
        push(8'h11);
        wr_reg(0, 8'h03);
        rd_reg(0, "R5 write one keeps flag, overrun bit ignored");
        wr_reg(1, 8'hFF);
        rd_reg(1, "R5 data write ignored");
        wr_reg(0, 8'h00);
        rd_reg(0, "R4 write zero clears");

        // R6, R7, R8
        push(8'h21);
        push(8'h22);
        rd_reg(1, "R7 old character kept");
        rd_reg(0, "R6 overrun set");
        rd_reg(0, "R8 arming read");
        idle();
        rd_reg(1, "R8 clearing data read");
        rd_reg(0, "R8 overrun cleared");
        push(8'h31);
        push(8'h32);
        wr_reg(0, 8'h00);
        push(8'h33);
        rd_reg(0, "R8 overrun persists without read sequence");
        rd_reg(1, "R8 data read armed");
        rd_reg(0, "R8 cleared after sequence");

        // R9: DMA path
        wr_reg(2, 8'h02);
        rd_reg(2, "R12 control readback");
        push(8'h44);
        cyc(0, 0, 0, 0, 0, 0, 1, "R9 dma ack");
        rd_reg(0, "R9 dma ack clears");

        // R10: race of clear and new character
        push(8'h50);
        cyc(1, 8'h51, 0, 1, 1, 0, 0, "R10 read races char");
        rd_reg(0, "R10 still ready, no overrun");
        cyc(1, 8'h52, 1, 0, 0, 8'h00, 0, "R10 write0 races char");
        cyc(1, 8'h53, 0, 0, 0, 0, 1, "R10 dma races char");
        rd_reg(1, "R10 newest char latched");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int op;
            bit cv;
            op = int'($urandom_range(0, 9));
            cv = ($urandom_range(0, 2) == 0);
            case (op)
                0, 1, 2: cyc(cv, 8'($urandom), 0, 1, 2'd0, 0, 0, "R12 random status");
                3, 4:    cyc(cv, 8'($urandom), 0, 1, 2'd1, 0, 0, "R3 random data");
                5:       cyc(cv, 8'($urandom), 1, 0, 2'd0, 8'($urandom), 0, "R4 random stat write");
                6:       cyc(cv, 8'($urandom), 1, 0, 2'($urandom), 8'($urandom), 0, "R12 random write");
                7:       cyc(cv, 8'($urandom), 0, 0, 2'd0, 0, 1, "R9 random ack");
                8:       cyc(cv, 8'($urandom), 0, 1, 2'($urandom), 0, 0, "R12 random read");
                default: cyc(cv, 8'($urandom), 0, 0, 2'd0, 0, 0, "R1 random idle");
            endcase
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule